// File: doc/BRIEF.md
# I2C Master Command-Queue Sequencer

This block is a bus master for two-wire serial transfers. A host pushes 9-bit command words into a 16-entry queue; each word asks for one byte to be written (the byte rides in the word) or one byte to be read. When the queue becomes non-empty the engine claims the bus with a START condition, sends the 7-bit target address with the direction of the head command, and then moves one byte per queued command. Bytes read from the target are placed in a 16-entry receive queue that the host drains one entry per pop.

Bus timing is paced by an external timing block that pulses `tick` once per quarter bit. Every bit takes four ticks. A change of direction in the queue either produces a repeated START, when that is enabled, or a STOP followed by a fresh START. With the stop-hold control set, a drained queue leaves the bus claimed with SCL low, so that more commands can extend the same transfer. A target that refuses the address or a written byte ends the transfer: the queue is flushed, a sticky abort flag is raised and STOP is sent.

Top module: `i2c_cmdq_master`

## Requirements
- R1: Command bit 8 selects the direction (1 = read, 0 = write). A write sends bits 7:0 most significant bit first, and a read returns the received byte on `rx_data` after a pop.
- R2: After START, the first byte on the bus is `{target_addr[6:0], d}`, where d is bit 8 of the command at the head of the queue.
- R3: Each queue holds 16 entries. `tx_not_full` is low while 16 commands wait. A push to a full command queue is dropped and sets `tx_overflow`.
- R4: A pop from an empty receive queue loads zero into `rx_data` and sets `rx_underflow`.
- R5: The master acknowledges each read byte that is followed by another read, and it NACKs the last read byte before a STOP or a direction change.
- R6: With `stop_hold` high and the queue empty, the bus stays claimed with SCL low and no STOP; later commands continue without a new START. Clearing `stop_hold` sends STOP.
- R7: With `restart_en` high, a direction change gives a repeated START with no STOP. With it low, a STOP comes first and then a new START.
- R8: A NACK on the address or on a written byte flushes the command queue, sets `tx_abort` and sends STOP.
- R9: `tx_empty`, `tx_not_full` and `rx_not_empty` reflect a push or pop from the clock edge that takes it. `master_active` is high from the cycle after the engine leaves idle until STOP completes.
- R10: With `enable` low no transfer starts. `enable_status` follows `enable` only while the engine is idle.
- R11: After reset both bus lines are released, the queues are empty, all flags are clear and `enable_status` is low.
- R12: Each bit takes four ticks and SDA moves while SCL is high only for START and STOP. With `tick` held high, a one-byte write lasts 82 cycles of `master_active` and an address NACK lasts 44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Engine enable |
| restart_en | input | 1 | Allow repeated START on direction change |
| stop_hold | input | 1 | Hold the bus instead of STOP when the queue drains |
| target_addr | input | 7 | 7-bit target address |
| cmd_push | input | 1 | Push `cmd_word` into the command queue |
| cmd_word | input | 9 | Bit 8 read flag, bits 7:0 write byte |
| rx_pop | input | 1 | Pop one received byte into `rx_data` |
| flag_clear | input | 1 | Clear the sticky flags |
| tick | input | 1 | Quarter-bit pacing pulse |
| sda_in | input | 1 | Sampled SDA line level |
| scl_out | output | 1 | SCL drive (0 pulls low, 1 releases) |
| sda_out | output | 1 | SDA drive (0 pulls low, 1 releases) |
| rx_data | output | 8 | Last popped received byte |
| master_active | output | 1 | Engine is running a transfer |
| rx_not_empty | output | 1 | Receive queue holds data |
| tx_empty | output | 1 | Command queue is empty |
| tx_not_full | output | 1 | Command queue has room |
| enable_status | output | 1 | Enable has taken effect |
| tx_abort | output | 1 | Sticky: target NACKed |
| tx_overflow | output | 1 | Sticky: push to a full command queue |
| rx_underflow | output | 1 | Sticky: pop from an empty receive queue |

## Verification
Queue status outputs change at the edge that takes a push or pop. The bench reads them at the falling edge after its one-cycle push or pop strobe, and reads `rx_data` and the sticky flags at that same point. Bus results take the full transfer: the engine leaves idle one edge after a push, START takes four ticks, each byte 36, STOP four. The bench waits for `master_active` low with the command queue empty before it compares what its target model logged. For the single-byte write vectors it also counts the exact number of active cycles (82, or 44 on an address NACK).

// File: rtl/i2c_cmdq_pkg.sv
package i2c_cmdq_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = BYTE_W + 1;
  localparam int ADDR_W = 7;
  localparam int RD_BIT = BYTE_W;   // read flag position in a command word
  localparam int BIT_TICKS = 4;     // quarter-bit phases per bit

  typedef enum logic [2:0] {
    EN_IDLE, EN_START, EN_ADDR, EN_WR, EN_RD, EN_NEXT, EN_STOP
  } eng_state_t;
endpackage

// File: rtl/i2c_cmdq_fifo.sv
module i2c_cmdq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  assign head  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R3
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !flush) |=> empty); // R4
endmodule

// File: rtl/i2c_cmdq_engine.sv
module i2c_cmdq_engine
  import i2c_cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic              restart_en,
  input  logic              stop_hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              rx_full,
  input  logic              sda_in,
  output logic              cmd_pop,
  output logic              abort,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_o,
  output logic              sda_o,
  output logic              busy,
  output logic              en_status
);
  localparam logic [1:0] PH_LAST  = 2'(BIT_TICKS - 1);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);

  eng_state_t        state;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic [BYTE_W-1:0] shreg;
  logic              rd_mode, nack_q, scl_q, sda_q;
  logic              in_byte, byte_end, head_rd, want_more_rd, take;

  always_comb begin
    head_rd      = cmd_word[RD_BIT];
    in_byte      = (state == EN_ADDR) || (state == EN_WR) || (state == EN_RD);
    byte_end     = tick && in_byte && (ph == PH_LAST) && (bitn == ACK_SLOT);
    rx_push      = byte_end && (state == EN_RD);
    abort        = byte_end && (state != EN_RD) && nack_q;
    want_more_rd = enable && ((cmd_valid && head_rd) || (!cmd_valid && stop_hold));
    take         = (state == EN_NEXT) && enable && cmd_valid &&
                   (head_rd == rd_mode) && !(head_rd && rx_full);
  end

  assign cmd_pop = take;
  assign rx_byte = shreg;
  assign scl_o   = scl_q;
  assign sda_o   = sda_q;
  assign busy    = (state != EN_IDLE);

  always_ff @(posedge clk) begin
    if (rst) en_status <= 1'b0;
    else if (state == EN_IDLE) en_status <= enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= EN_IDLE;
      ph      <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rd_mode <= 1'b0;
      nack_q  <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      case (state)
        EN_IDLE: begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
          ph    <= '0;
          if (enable && cmd_valid) begin
            rd_mode <= head_rd;
            state   <= EN_START;
          end
        end
        EN_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b0;
            default: begin
              scl_q <= 1'b0;
              shreg <= {addr, rd_mode};
              bitn  <= '0;
              state <= EN_ADDR;
            end
          endcase
        end
        EN_ADDR, EN_WR, EN_RD: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: begin
              if (bitn == ACK_SLOT) sda_q <= (state == EN_RD) ? !want_more_rd : 1'b1;
              else                  sda_q <= (state == EN_RD) ? 1'b1 : shreg[BYTE_W-1];
            end
            2'd1: scl_q <= 1'b1;
            2'd2: begin
              if (bitn == ACK_SLOT) nack_q <= sda_in;
              else                  shreg  <= {shreg[BYTE_W-2:0], sda_in};
            end
            default: begin
              scl_q <= 1'b0;
              if (bitn == ACK_SLOT) state <= abort ? EN_STOP : EN_NEXT;
              else                  bitn  <= bitn + 4'd1;
            end
          endcase
        end
        EN_NEXT: begin
          ph <= '0;
          if (take) begin
            shreg <= cmd_word[BYTE_W-1:0];
            bitn  <= '0;
            state <= head_rd ? EN_RD : EN_WR;
          end else if (!enable) begin
            state <= EN_STOP;
          end else if (cmd_valid && (head_rd != rd_mode)) begin
            if (restart_en) begin
              rd_mode <= head_rd;
              state   <= EN_START;
            end else begin
              state <= EN_STOP;
            end
          end else if (!cmd_valid && !stop_hold) begin
            state <= EN_STOP;
          end
        end
        EN_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b1;
            default: state <= EN_IDLE;
          endcase
        end
        default: state <= EN_IDLE;
      endcase
    end
  end

  AST_SDA_MOVES_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |->
      (($past(state) == EN_START) || ($past(state) == EN_STOP))); // R12
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == EN_NEXT) |-> !scl_q); // R6
  AST_ABORT_TO_STOP: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state == EN_STOP)); // R8
endmodule

// File: rtl/i2c_cmdq_master.sv
module i2c_cmdq_master
  import i2c_cmdq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int RX_DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              restart_en,
  input  logic              stop_hold,
  input  logic [ADDR_W-1:0] target_addr,
  input  logic              cmd_push,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              rx_pop,
  input  logic              flag_clear,
  input  logic              tick,
  input  logic              sda_in,
  output logic              scl_out,
  output logic              sda_out,
  output logic [BYTE_W-1:0] rx_data,
  output logic              master_active,
  output logic              rx_not_empty,
  output logic              tx_empty,
  output logic              tx_not_full,
  output logic              enable_status,
  output logic              tx_abort,
  output logic              tx_overflow,
  output logic              rx_underflow
);
  logic [CMD_W-1:0]  cmd_head;
  logic              cmd_empty, cmd_full, eng_pop, eng_abort;
  logic [BYTE_W-1:0] rx_head, eng_rx_byte;
  logic              rx_empty, rx_full, eng_rx_push;
  logic              eng_busy, eng_en_st;

  i2c_cmdq_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst(rst), .push(cmd_push), .wdata(cmd_word), .pop(eng_pop),
    .flush(eng_abort), .head(cmd_head), .empty(cmd_empty), .full(cmd_full));

  i2c_cmdq_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(eng_rx_push), .wdata(eng_rx_byte),
    .pop(rx_pop && !rx_empty), .flush(1'b0), .head(rx_head),
    .empty(rx_empty), .full(rx_full));

  i2c_cmdq_engine u_eng (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable),
    .restart_en(restart_en), .stop_hold(stop_hold), .addr(target_addr),
    .cmd_valid(!cmd_empty), .cmd_word(cmd_head), .rx_full(rx_full),
    .sda_in(sda_in), .cmd_pop(eng_pop), .abort(eng_abort),
    .rx_push(eng_rx_push), .rx_byte(eng_rx_byte), .scl_o(scl_out),
    .sda_o(sda_out), .busy(eng_busy), .en_status(eng_en_st));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data      <= '0;
      tx_abort     <= 1'b0;
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      if (rx_pop) rx_data <= rx_empty ? '0 : rx_head;
      tx_abort     <= (tx_abort && !flag_clear) || eng_abort;
      tx_overflow  <= (tx_overflow && !flag_clear) || (cmd_push && cmd_full);
      rx_underflow <= (rx_underflow && !flag_clear) || (rx_pop && rx_empty);
    end
  end

  assign master_active = eng_busy;
  assign enable_status = eng_en_st;
  assign rx_not_empty  = !rx_empty;
  assign tx_empty      = cmd_empty;
  assign tx_not_full   = !cmd_full;

  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cmd_push && !tx_not_full) |=> tx_overflow); // R3
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_not_empty) |=> ((rx_data == '0) && rx_underflow)); // R4
  AST_DISABLE_SETTLES: assert property (@(posedge clk) disable iff (rst)
    (!enable && !master_active) |=> (!enable_status && !master_active)); // R10
endmodule

// File: tb/sim_i2c_cmdq_master.sv
module sim_i2c_cmdq_master;
  localparam logic [6:0] SLV = 7'h2C;
  localparam int NVEC = 5;
  // {expect_abort, address, write byte}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 7'h2C, 8'h5A}, {1'b0, 7'h2C, 8'h00}, {1'b0, 7'h2C, 8'hFF},
    {1'b1, 7'h2D, 8'h33}, {1'b0, 7'h2C, 8'h81}};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, enable = 1'b0, restart_en = 1'b0, stop_hold = 1'b0;
  logic [6:0] target_addr = SLV;
  logic cmd_push = 1'b0, rx_pop = 1'b0, flag_clear = 1'b0, tick = 1'b1;
  logic [8:0] cmd_word = '0;
  logic scl_out, sda_out, master_active, rx_not_empty, tx_empty, tx_not_full;
  logic enable_status, tx_abort, tx_overflow, rx_underflow;
  logic [7:0] rx_data;
  logic sl_sda = 1'b1;
  wire  sda_bus = sda_out & sl_sda;

  i2c_cmdq_master u0 (
    .clk(clk), .rst(rst), .enable(enable), .restart_en(restart_en),
    .stop_hold(stop_hold), .target_addr(target_addr), .cmd_push(cmd_push),
    .cmd_word(cmd_word), .rx_pop(rx_pop), .flag_clear(flag_clear),
    .tick(tick), .sda_in(sda_bus), .scl_out(scl_out), .sda_out(sda_out),
    .rx_data(rx_data), .master_active(master_active),
    .rx_not_empty(rx_not_empty), .tx_empty(tx_empty),
    .tx_not_full(tx_not_full), .enable_status(enable_status),
    .tx_abort(tx_abort), .tx_overflow(tx_overflow),
    .rx_underflow(rx_underflow));

  // ---- target model ----
  int b = 0, n_start = 0, n_stop = 0, n_wr = 0, n_mack = 0, rd_idx = 0;
  bit active = 0, is_addr = 0, matched = 0, xmit = 0, mack = 0;
  logic [7:0] sr = '0, txb = '0, last_addr = '0;
  logic [7:0] wr_log [64];
  logic       mack_log [64];

  always @(negedge sda_bus) if (scl_out) begin
    active = 1; is_addr = 1; xmit = 0; b = 0; n_start++;
  end
  always @(posedge sda_bus) if (scl_out) begin
    active = 0; xmit = 0; n_stop++;
  end
  always @(posedge scl_out) if (active) begin
    if (b < 8) sr = {sr[6:0], sda_bus};
    else       mack = sda_bus;
    b++;
  end
  always @(negedge scl_out) if (active) begin
    if (b == 8) begin
      if (is_addr) begin
        last_addr = sr; matched = (sr[7:1] == SLV);
        sl_sda = matched ? 1'b0 : 1'b1;
      end else if (xmit) begin
        sl_sda = 1'b1;
      end else begin
        wr_log[n_wr % 64] = sr; n_wr++;
        sl_sda = (sr == 8'hEE) ? 1'b1 : 1'b0;
      end
    end else if (b == 9) begin
      b = 0;
      if (is_addr) begin
        is_addr = 0;
        if (!matched) begin active = 0; sl_sda = 1'b1; end
        else if (sr[0]) begin xmit = 1; rd_idx = 0; txb = 8'hA0; sl_sda = txb[7]; end
        else sl_sda = 1'b1;
      end else if (xmit) begin
        mack_log[n_mack % 64] = mack; n_mack++;
        if (!mack) begin rd_idx++; txb = 8'hA0 + 8'(rd_idx); sl_sda = txb[7]; end
        else begin xmit = 0; sl_sda = 1'b1; end
      end else sl_sda = 1'b1;
    end else if (b >= 1 && b <= 7 && xmit) begin
      sl_sda = txb[7 - b];
    end
  end

  // ---- checking ----
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [8:0] w);
    @(negedge clk); cmd_push = 1'b1; cmd_word = w;
    @(negedge clk); cmd_push = 1'b0;
  endtask

  task automatic pop_rx;
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic clear_flags;
    @(negedge clk); flag_clear = 1'b1;
    @(negedge clk); flag_clear = 1'b0;
  endtask

  // counts samples with master_active high until the bus is idle and the queue empty
  task automatic wait_txn(output int act_cycles);
    act_cycles = 0;
    for (int k = 0; k < 20000; k++) begin
      if (master_active) act_cycles++;
      if (k > 2 && !master_active && tx_empty) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, s0, p0, w0, m0;
    logic [15:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 scl", scl_out, 1);
    chk("R11 sda", sda_out, 1);
    chk("R11 tx_empty", tx_empty, 1);
    chk("R11 tx_not_full", tx_not_full, 1);
    chk("R11 rx_not_empty", rx_not_empty, 0);
    chk("R11 flags", {tx_abort, tx_overflow, rx_underflow, master_active}, 0);
    chk("R11 enable_status", enable_status, 0);

    enable = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 enable_status on", enable_status, 1);

    // vector table: single-byte writes
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      target_addr = v[14:8];
      w0 = n_wr;
      push({1'b0, v[7:0]});
      wait_txn(cyc);
      chk("R2 address byte", last_addr, {v[14:8], 1'b0});
      chk("R8 abort flag", tx_abort, v[15]);
      chk("R12 active cycles", cyc, v[15] ? 44 : 82);
      if (!v[15]) chk("R1 write byte", wr_log[w0 % 64], v[7:0]);
      else        chk("R8 nothing written", n_wr, w0);
      clear_flags();
    end
    target_addr = SLV;

    // reads with ACK/NACK
    m0 = n_mack;
    push(9'h100); push(9'h100); push(9'h100);
    wait_txn(cyc);
    chk("R2 read address", last_addr, {SLV, 1'b1});
    chk("R9 rx_not_empty", rx_not_empty, 1);
    for (int i = 0; i < 3; i++) begin
      pop_rx();
      chk("R1 read byte", rx_data, 8'hA0 + i);
    end
    chk("R5 ack first", mack_log[m0 % 64], 0);
    chk("R5 ack second", mack_log[(m0 + 1) % 64], 0);
    chk("R5 nack last", mack_log[(m0 + 2) % 64], 1);

    // underflow
    pop_rx();
    chk("R4 zero data", rx_data, 0);
    chk("R4 underflow flag", rx_underflow, 1);
    clear_flags();

    // gating, fill and overflow
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 enable_status off", enable_status, 0);
    w0 = n_wr;
    push(9'h000);
    chk("R9 tx_empty after push", tx_empty, 0);
    for (int i = 1; i < 16; i++) push(9'(i));
    chk("R3 full", tx_not_full, 0);
    chk("R10 no transfer while disabled", master_active, 0);
    push(9'h077);
    chk("R3 overflow flag", tx_overflow, 1);
    clear_flags();
    enable = 1'b1;
    wait_txn(cyc);
    chk("R3 sixteen sent", n_wr - w0, 16);
    chk("R3 dropped push absent", wr_log[(w0 + 15) % 64], 8'h0F);

    // stop hold
    stop_hold = 1'b1;
    s0 = n_start; p0 = n_stop; w0 = n_wr;
    push(9'h042);
    while (!tx_empty) @(negedge clk);
    repeat (60) @(negedge clk);
    chk("R6 still active", master_active, 1);
    chk("R6 scl low", scl_out, 0);
    chk("R6 no stop", n_stop, p0);
    push(9'h043);
    repeat (60) @(negedge clk);
    chk("R6 second byte", wr_log[(w0 + 1) % 64], 8'h43);
    chk("R6 no new start", n_start, s0 + 1);
    stop_hold = 1'b0;
    wait_txn(cyc);
    chk("R6 stop after release", n_stop, p0 + 1);

    // direction change with repeated START
    restart_en = 1'b1;
    s0 = n_start; p0 = n_stop;
    push(9'h010); push(9'h100);
    wait_txn(cyc);
    chk("R7 restart starts", n_start, s0 + 2);
    chk("R7 restart stops", n_stop, p0 + 1);
    pop_rx();
    chk("R7 read after restart", rx_data, 8'hA0);

    // direction change without repeated START
    restart_en = 1'b0;
    s0 = n_start; p0 = n_stop;
    push(9'h011); push(9'h100);
    wait_txn(cyc);
    chk("R7 plain starts", n_start, s0 + 2);
    chk("R7 plain stops", n_stop, p0 + 2);
    pop_rx();
    chk("R7 read after stop", rx_data, 8'hA0);

    // NACK on a written byte
    w0 = n_wr; p0 = n_stop;
    push(9'h0EE); push(9'h011); push(9'h022);
    wait_txn(cyc);
    chk("R8 abort on data nack", tx_abort, 1);
    chk("R8 queue flushed", tx_empty, 1);
    chk("R8 one byte sent", n_wr - w0, 1);
    chk("R8 stop sent", n_stop, p0 + 1);
    clear_flags();
    chk("R8 flag cleared", tx_abort, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule